// File: doc/BRIEF.md
# Indexed Port NVRAM Access Bridge

This block turns a narrow window of four byte-wide I/O ports into reads and writes on a byte store that it holds itself. The store has a 16-bit address space and a depth set by a parameter. Software does not address the store directly. It first loads an internal address register one byte at a time through two address ports. It then moves a byte through the data port. Every write through the data port returns the address register to zero, so each store write must reload the address. A read leaves the address where it was.

Two 16-byte regions at the bottom of the store can be locked, each by its own lock bit. A lock bit is flipped by a toggle command. The command names one lock bit and inverts it. While a region is locked, writes into it are dropped and reads from it give 0xFF. Addresses at or past the end of the store behave the same way.

Port accesses arrive on a valid/ready request channel. Read data leaves on a valid/ready response channel. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a response is waiting and `rsp_ready` is low, so the block holds at most one response at a time. Each read produces exactly one response, in the cycle after it is accepted. Writes produce no response. A waiting response keeps its data unchanged until `rsp_ready` takes it. The lock toggle is a plain single-cycle control pulse and is not part of either channel.

Top module: `nvb_bridge`

## Requirements
- R1: An accepted write to port 0 replaces bits 7:0 of the address register with the write data and keeps bits 15:8.
- R2: An accepted write to port 1 replaces bits 15:8 of the address register with the write data and keeps bits 7:0.
- R3: An accepted write to port 3 stores the data byte at the current address, when that address is accessible, and then sets the address register to 0x0000.
- R4: An accepted read of port 3 returns the byte at the current address and leaves the address register unchanged.
- R5: An accepted read of port 0, 1 or 2 returns 0xFF.
- R6: A write to port 2 changes neither the address register nor the store.
- R7: While lock bit 0 is set, addresses 0x0020 to 0x002F are blocked. While lock bit 1 is set, addresses 0x0030 to 0x003F are blocked. A write to a blocked address is dropped, and a read from it returns 0xFF. Addresses outside those two regions are never blocked by a lock bit.
- R8: A one-cycle `lock_toggle` pulse inverts the lock bit selected by `lock_idx` and leaves the other lock bit unchanged.
- R9: An address at or beyond MEM_BYTES (default 1024) is ignored on a port 3 write and returns 0xFF on a port 3 read.
- R10: Reset sets the address register to 0x0000 and both lock bits to zero. Reset leaves the store contents unchanged.
- R11: A read produces one response, one cycle after it is accepted. A write produces no response. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, and `rsp_rdata` and `rsp_valid` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A port access request is present |
| req_ready | output | 1 | The block can accept a request this cycle |
| req_write | input | 1 | 1 for a port write, 0 for a port read |
| req_port | input | 2 | Port offset: 0 = address low byte, 1 = address high byte, 2 = unused, 3 = data |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Read data is present |
| rsp_ready | input | 1 | The consumer takes the read data |
| rsp_rdata | output | 8 | Read data |
| lock_toggle | input | 1 | Pulse that inverts one lock bit |
| lock_idx | input | LOCK_IDX_W | Selects the lock bit to invert |

## Verification
The hardest case to reach from the ports is the interaction between the address register, the locks and the flow control. The locks and the address register can only be observed through port 3 reads. Those reads can in turn be delayed by a stalled response channel. The stimulus therefore steers the address into each locked region and onto its boundary addresses, toggles each lock between accesses, and inserts a port 2 write between an address load and a read. Later it runs a long series of reads and writes while the response consumer drops `rsp_ready` on an irregular pattern. A final reset, applied while both locks are set and an address is loaded, shows that the locks and the address register clear while earlier store writes remain.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
  typedef enum logic [1:0] {
    PORT_ADDR_LO = 2'd0,
    PORT_ADDR_HI = 2'd1,
    PORT_UNUSED  = 2'd2,
    PORT_DATA    = 2'd3
  } nvb_port_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] FILL_BYTE = '1;
endpackage

// File: rtl/nvb_addr_latch.sv
module nvb_addr_latch
  import nvb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              clr,
  input  logic [BYTE_W-1:0] din,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      addr_q <= '0;
    end else begin
      if (ld_lo) addr_q[BYTE_W-1:0]      <= din;
      if (ld_hi) addr_q[ADDR_W-1:BYTE_W] <= din;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/nvb_lock_ctrl.sv
module nvb_lock_ctrl
  import nvb_pkg::*;
#(
  parameter int NUM_LOCKS     = 2,
  parameter int LOCK_BASE     = 32,
  parameter int LOCK_WIN_BITS = 4,
  parameter int LOCK_IDX_W    = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  toggle,
  input  logic [LOCK_IDX_W-1:0] idx,
  input  logic [ADDR_W-1:0]     addr,
  output logic [NUM_LOCKS-1:0]  lock_bits,
  output logic                  blocked
);
  localparam int BASE_BLK = LOCK_BASE >> LOCK_WIN_BITS;

  logic [NUM_LOCKS-1:0] lock_q;
  logic [NUM_LOCKS-1:0] win_hit;
  logic [ADDR_W-LOCK_WIN_BITS-1:0] blk;

  assign blk = addr[ADDR_W-1:LOCK_WIN_BITS];

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
    always_ff @(posedge clk) begin
      if (rst)                               lock_q[i] <= 1'b0;
      else if (toggle && (32'(idx) == i))    lock_q[i] <= ~lock_q[i];
    end
    assign win_hit[i] = (32'(blk) == BASE_BLK + i);
  end

  assign lock_bits = lock_q;
  assign blocked   = |(win_hit & lock_q);
endmodule

// File: rtl/nvb_store.sv
module nvb_store
  import nvb_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int IDX_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/nvb_bridge.sv
module nvb_bridge
  import nvb_pkg::*;
#(
  parameter int MEM_BYTES     = 1024,
  parameter int NUM_LOCKS     = 2,
  parameter int LOCK_BASE     = 32,
  parameter int LOCK_WIN_BITS = 4,
  parameter int LOCK_IDX_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [1:0]            req_port,
  input  logic [7:0]            req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [7:0]            rsp_rdata,
  input  logic                  lock_toggle,
  input  logic [LOCK_IDX_W-1:0] lock_idx
);
  localparam int IDX_W = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;

  nvb_port_e            port;
  logic                 acc, acc_wr, acc_rd;
  logic [ADDR_W-1:0]    addr_q;
  logic [NUM_LOCKS-1:0] lock_q;
  logic                 blocked, in_range, allowed;
  logic [BYTE_W-1:0]    mem_rdata;
  logic                 rsp_valid_q;
  logic [BYTE_W-1:0]    rsp_rdata_q;

  assign port      = nvb_port_e'(req_port);
  assign req_ready = !rsp_valid_q || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign acc_wr    = acc && req_write;
  assign acc_rd    = acc && !req_write;
  assign in_range  = (32'(addr_q) < MEM_BYTES);
  assign allowed   = in_range && !blocked;

  nvb_addr_latch u_addr (
    .clk   (clk),
    .rst   (rst),
    .ld_lo (acc_wr && port == PORT_ADDR_LO),
    .ld_hi (acc_wr && port == PORT_ADDR_HI),
    .clr   (acc_wr && port == PORT_DATA),
    .din   (req_wdata),
    .addr  (addr_q)
  );

  nvb_lock_ctrl #(
    .NUM_LOCKS     (NUM_LOCKS),
    .LOCK_BASE     (LOCK_BASE),
    .LOCK_WIN_BITS (LOCK_WIN_BITS),
    .LOCK_IDX_W    (LOCK_IDX_W)
  ) u_lock (
    .clk       (clk),
    .rst       (rst),
    .toggle    (lock_toggle),
    .idx       (lock_idx),
    .addr      (addr_q),
    .lock_bits (lock_q),
    .blocked   (blocked)
  );

  nvb_store #(
    .DEPTH (MEM_BYTES),
    .IDX_W (IDX_W)
  ) u_store (
    .clk   (clk),
    .we    (acc_wr && port == PORT_DATA && allowed),
    .idx   (addr_q[IDX_W-1:0]),
    .wdata (req_wdata),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= FILL_BYTE;
    end else if (acc_rd) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= (port == PORT_DATA && allowed) ? mem_rdata : FILL_BYTE;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/nvb_bridge_chk.sv
module nvb_bridge_chk #(
  parameter int MEM_BYTES     = 1024,
  parameter int NUM_LOCKS     = 2,
  parameter int LOCK_BASE     = 32,
  parameter int LOCK_WIN_BITS = 4,
  parameter int LOCK_IDX_W    = 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  req_write,
  input logic [1:0]            req_port,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [7:0]            rsp_rdata,
  input logic                  lock_toggle,
  input logic [LOCK_IDX_W-1:0] lock_idx,
  input logic [15:0]           addr_q,
  input logic [NUM_LOCKS-1:0]  lock_q
);
  logic acc_rd, acc_wr;
  assign acc_rd = req_valid && req_ready && !req_write;
  assign acc_wr = req_valid && req_ready && req_write;

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  a_r11_backpressure: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |-> !req_ready);

  a_r11_read_gives_rsp: assert property (@(posedge clk) disable iff (rst)
    acc_rd |=> rsp_valid);

  a_r5_nondata_read: assert property (@(posedge clk) disable iff (rst)
    acc_rd && req_port != 2'd3 |=> rsp_rdata == 8'hFF);

  a_r3_addr_clear: assert property (@(posedge clk) disable iff (rst)
    acc_wr && req_port == 2'd3 |=> addr_q == 16'h0000);

  a_r4_read_keeps_addr: assert property (@(posedge clk) disable iff (rst)
    acc_rd |=> $stable(addr_q));

  a_r6_unused_write: assert property (@(posedge clk) disable iff (rst)
    acc_wr && req_port == 2'd2 |=> $stable(addr_q));

  a_r8_toggle_one: assert property (@(posedge clk) disable iff (rst)
    lock_toggle && (32'(lock_idx) < NUM_LOCKS) |=> $countones(lock_q ^ $past(lock_q)) == 1);

  a_r8_no_toggle: assert property (@(posedge clk) disable iff (rst)
    !lock_toggle |=> $stable(lock_q));

  a_r7_locked_read: assert property (@(posedge clk) disable iff (rst)
    acc_rd && req_port == 2'd3 && lock_q[0] &&
    (32'(addr_q >> LOCK_WIN_BITS) == (LOCK_BASE >> LOCK_WIN_BITS)) |=> rsp_rdata == 8'hFF);

  a_r9_range_read: assert property (@(posedge clk) disable iff (rst)
    acc_rd && req_port == 2'd3 && (32'(addr_q) >= MEM_BYTES) |=> rsp_rdata == 8'hFF);
endmodule

bind nvb_bridge nvb_bridge_chk #(
  .MEM_BYTES     (MEM_BYTES),
  .NUM_LOCKS     (NUM_LOCKS),
  .LOCK_BASE     (LOCK_BASE),
  .LOCK_WIN_BITS (LOCK_WIN_BITS),
  .LOCK_IDX_W    (LOCK_IDX_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_port    (req_port),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .lock_toggle (lock_toggle),
  .lock_idx    (lock_idx),
  .addr_q      (addr_q),
  .lock_q      (lock_q)
);

// File: tb/nvb_bridge_tb_top.sv
`timescale 1ns/1ps
module nvb_bridge_tb_top;
  localparam int MEM = 1024;

  logic       clk = 0;
  logic       rst = 1;
  logic       req_valid = 0, req_write = 0;
  logic [1:0] req_port = 0;
  logic [7:0] req_wdata = 0;
  logic       req_ready, rsp_valid;
  logic       rsp_ready = 1;
  logic [7:0] rsp_rdata;
  logic       lock_toggle = 0;
  logic [0:0] lock_idx = 0;

  always #10 clk = ~clk;

  nvb_bridge #(.MEM_BYTES(MEM)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_port(req_port), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .lock_toggle(lock_toggle), .lock_idx(lock_idx));

  int checks = 0, errors = 0, cyc = 0, stall_cnt = 0;
  bit stall_mode = 0;

  // behavioural reference model
  int       m_addr = 0;
  bit [1:0] m_lock = 0;
  bit [7:0] m_mem [int];
  bit [7:0] exp_q[$];
  string    tag_q[$];

  function automatic bit m_ok();
    if (m_addr >= MEM) return 0;
    if (m_addr >= 'h20 && m_addr <= 'h2F && m_lock[0]) return 0;
    if (m_addr >= 'h30 && m_addr <= 'h3F && m_lock[1]) return 0;
    return 1;
  endfunction

  function automatic void m_apply(bit wr, bit [1:0] p, bit [7:0] d, string tag);
    if (wr) begin
      if (p == 0) m_addr = (m_addr & 'hFF00) | d;
      else if (p == 1) m_addr = (m_addr & 'h00FF) | (int'(d) << 8);
      else if (p == 3) begin
        if (m_ok()) m_mem[m_addr] = d;
        m_addr = 0;
      end
    end else begin
      if (p == 3 && m_ok()) exp_q.push_back(m_mem.exists(m_addr) ? m_mem[m_addr] : 8'h00);
      else exp_q.push_back(8'hFF);
      tag_q.push_back(tag);
    end
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(bit wr, bit [1:0] p, bit [7:0] d, string tag);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_port = p; req_wdata = d;
    while (!req_ready) @(negedge clk);
    m_apply(wr, p, d, tag);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic set_addr(int a);
    access(1, 0, a[7:0], "addr");
    access(1, 1, a[15:8], "addr");
  endtask

  task automatic wr_at(int a, bit [7:0] d);
    set_addr(a);
    access(1, 3, d, "wr");
  endtask

  task automatic rd_at(int a, string tag);
    set_addr(a);
    access(0, 3, 0, tag);
  endtask

  task automatic toggle(int i);
    @(negedge clk);
    lock_toggle = 1; lock_idx = i[0:0];
    m_lock[i] = ~m_lock[i];
    @(posedge clk); #1;
    lock_toggle = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // response channel ready pattern
  always @(posedge clk) begin
    #2;
    stall_cnt++;
    rsp_ready = stall_mode ? (stall_cnt[0] ^ stall_cnt[2]) : 1'b1;
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check(0, "R11 unexpected response", rsp_rdata, 0);
      else begin
        automatic bit [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rsp_rdata == e, t, rsp_rdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(req_ready == 1, "R10 reset ready", req_ready, 1);
    check(rsp_valid == 0, "R10 reset no rsp", rsp_valid, 0);

    // R3: data write clears address
    access(1, 3, 8'h11, "wr");           // address 0 after reset
    wr_at('h0005, 8'hA5);
    access(0, 3, 0, "R3 address cleared after data write");
    // R4: read keeps address
    set_addr('h0005);
    access(0, 3, 0, "R4 read data");
    access(0, 3, 0, "R4 address kept by read");

    // R1 / R2
    wr_at('h0122, 8'h7E);
    wr_at('h0123, 8'h3C);
    set_addr('h0123);
    access(1, 0, 8'h22, "addr");
    access(0, 3, 0, "R1 low byte replaced");
    access(1, 1, 8'h00, "addr");
    access(1, 1, 8'h01, "addr");
    access(0, 3, 0, "R2 high byte replaced");

    // R5
    access(0, 0, 0, "R5 port0 read");
    access(0, 1, 0, "R5 port1 read");
    access(0, 2, 0, "R5 port2 read");

    // R6
    wr_at('h0010, 8'h33);
    set_addr('h0010);
    access(1, 2, 8'h99, "R6");
    access(0, 3, 0, "R6 port2 write ignored");

    // R7 / R8 lock windows
    wr_at('h0025, 8'h44);
    wr_at('h0035, 8'h55);
    wr_at('h001F, 8'h1F);
    wr_at('h0040, 8'h40);
    wr_at('h0020, 8'h20);
    wr_at('h002F, 8'h2F);
    toggle(0);
    wr_at('h0025, 8'h66);
    rd_at('h0025, "R7 lock0 read blocked");
    rd_at('h0020, "R7 lock0 low edge");
    rd_at('h002F, "R7 lock0 high edge");
    rd_at('h001F, "R7 below window open");
    rd_at('h0035, "R8 lock1 still clear");
    toggle(1);
    rd_at('h0035, "R8 lock1 set");
    rd_at('h0040, "R7 above window open");
    toggle(0);
    rd_at('h0025, "R8 lock0 toggled back, write was dropped");
    rd_at('h0035, "R8 lock1 unaffected");

    // R9
    wr_at('h0400, 8'h12);
    rd_at('h0400, "R9 first out of range");
    rd_at('h1234, "R9 far out of range");
    wr_at('h03FF, 8'hC3);
    rd_at('h03FF, "R9 last in range");

    // R11 under back-pressure
    stall_mode = 1;
    for (int i = 0; i < 12; i++) wr_at('h0100 + i, 8'(i * 7 + 3));
    for (int i = 0; i < 12; i++) rd_at('h0100 + i, "R11 stalled read");
    for (int i = 0; i < 6; i++) access(0, 2'(i % 3), 0, "R11 stalled port read");
    drain();
    stall_mode = 0;
    @(negedge clk);

    // R10: reset with locks set and address loaded
    toggle(0);
    set_addr('h0025);
    drain();
    rst = 1;
    m_addr = 0; m_lock = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(rsp_valid == 0, "R10 no rsp after reset", rsp_valid, 0);
    access(0, 3, 0, "R10 address cleared, store kept");
    rd_at('h0025, "R10 locks cleared");
    rd_at('h0035, "R10 lock1 cleared");

    drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule